// File: doc/BRIEF.md
# Asynchronous byte serial port

This block is a full-duplex asynchronous serial port of the kind found beside a small microcontroller core. It moves bytes in 10-bit frames: a low start bit, eight data bits with the least significant bit first, and a high stop bit. A shared one-cycle tick input, supplied by a baud-rate generator outside the block, sets the timing. That tick runs at `OVS` times the bit rate, so one bit lasts `OVS` ticks.

The host side loads a byte with a one-cycle write strobe, and the frame starts at once. The transmitter and the receiver run independently. The host watches three sticky status flags: transmit done, receive done, and the ninth received bit (the stop bit). The host clears the two done flags with their own strobes. A single interrupt line reports either done flag when the enable input allows it.

The receiver has three protections against bad input. It ignores a low pulse shorter than half a bit. It takes each bit as a vote of three samples. It refuses to overwrite a byte that the host has not yet acknowledged.

Top module: `async_byte_port`

## Requirements
- R1: While no frame is in progress, `txd_o` is 1. A write to `tx_wr_i` while idle sends a frame on `txd_o`. The frame is one start bit at 0, then `tx_data_i[0]` through `tx_data_i[7]` in that order, then one stop bit at 1. Each bit lasts `OVS` ticks of `tick_i`.
- R2: `tx_done_o` becomes 1 in the same clock cycle that `txd_o` starts the stop bit. It stays 0 during the data bits.
- R3: A write to `tx_wr_i` while a frame is being sent is ignored. The frame in progress is unchanged, and no second frame follows it.
- R4: Reception happens only while `rx_en_i` is 1. A frame that arrives while `rx_en_i` is 0 changes nothing. Dropping `rx_en_i` during a frame abandons that frame.
- R5: A received frame is committed at mid stop bit if the commit conditions hold. On commit, the data byte goes to `rx_data_o`, the stop bit goes to `rx_bit9_o`, and `rx_done_o` becomes 1. Each bit value is the majority of the line samples taken at ticks `OVS/2-1`, `OVS/2` and `OVS/2+1` of that bit.
- R6: If `rx_done_o` is already 1 when a frame ends, `rx_data_o`, `rx_bit9_o` and `rx_done_o` keep their values.
- R7: With `mp_qual_i` at 1, a frame whose stop bit is 0 is not committed, and all three receive outputs keep their values. With `mp_qual_i` at 0, such a frame is committed and `rx_bit9_o` becomes 0.
- R8: A low pulse on `rxd_i` that is back high at mid start bit is a false start. The receiver returns to idle without committing anything, and a frame that follows is received correctly.
- R9: `irq_o` is 1 exactly when `irq_en_i` is 1 and at least one of `tx_done_o` and `rx_done_o` is 1.
- R10: A 1 on `tx_done_clr_i` or `rx_done_clr_i` clears its own flag at the next edge. A clear wins over a set in the same cycle.
- R11: After reset, `txd_o` is 1, the three flags and `irq_o` are 0, and `rx_data_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse at OVS times the bit rate |
| tx_wr_i | input | 1 | Write strobe that loads `tx_data_i` and starts a frame |
| tx_data_i | input | 8 | Byte to send |
| txd_o | output | 1 | Serial output, idles high |
| rxd_i | input | 1 | Serial input, asynchronous |
| rx_en_i | input | 1 | Receive enable |
| mp_qual_i | input | 1 | When 1, only frames with a high stop bit are committed |
| rx_data_o | output | 8 | Last committed byte |
| rx_bit9_o | output | 1 | Stop bit of the last committed frame |
| tx_done_o | output | 1 | Transmit done flag |
| rx_done_o | output | 1 | Receive done flag |
| tx_done_clr_i | input | 1 | Clears `tx_done_o` |
| rx_done_clr_i | input | 1 | Clears `rx_done_o` |
| irq_en_i | input | 1 | Interrupt enable |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench keeps the default `OVS` of 16 and pulses `tick_i` every second clock, so one bit spans 32 clocks and a full frame about 320. These values keep the three-sample vote window at ticks 7 to 9 and the half-bit false-start test at the sizes the requirements describe. A frame is still short enough to run many random bytes, plus the directed cases for a full receive flag, the stop-bit qualification, dropping the enable and a clear that coincides with a set.

// File: rtl/abp_pkg.sv
package abp_pkg;

    localparam int unsigned ABP_DW = 8;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_e;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/abp_tx.sv
module abp_tx #(
    parameter int unsigned OVS = 16,
    parameter int unsigned DW  = abp_pkg::ABP_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          wr_i,
    input  logic [DW-1:0] data_i,
    output logic          txd_o,
    output logic          set_o
);
    localparam int unsigned CW = (OVS > 1) ? $clog2(OVS) : 1;
    localparam int unsigned IW = $clog2(DW + 2);
    localparam int unsigned FW = DW + 2;

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        logic [IW-1:0] idx;
        logic [FW-1:0] sh;
    } tx_s;

    tx_s q, d;

    always_comb begin
        d     = q;
        set_o = 1'b0;
        if (!q.busy) begin
            if (wr_i) begin
                d.busy = 1'b1;
                d.sh   = {1'b1, data_i, 1'b0};
                d.cnt  = '0;
                d.idx  = '0;
            end
        end else if (tick_i) begin
            if (q.cnt == CW'(OVS - 1)) begin
                d.cnt = '0;
                d.sh  = {1'b1, q.sh[FW-1:1]};
                d.idx = q.idx + 1'b1;
                if (q.idx == IW'(DW)) begin
                    set_o = 1'b1;
                end
                if (q.idx == IW'(DW + 1)) begin
                    d.busy = 1'b0;
                end
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.busy <= 1'b0;
            q.cnt  <= '0;
            q.idx  <= '0;
            q.sh   <= '1;
        end else begin
            q <= d;
        end
    end

    assign txd_o = q.busy ? q.sh[0] : 1'b1;

    // R1
    start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !q.busy) |=> (q.busy && !txd_o));

    // R3
    busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && q.busy && !tick_i) |=> $stable(q.sh));

    // R2
    stop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_o |=> (txd_o && q.busy));

endmodule

// File: rtl/abp_rx.sv
module abp_rx #(
    parameter int unsigned OVS = 16,
    parameter int unsigned DW  = abp_pkg::ABP_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          rxd_i,
    input  logic          en_i,
    output logic          req_o,
    output logic [DW-1:0] data_o,
    output logic          stop_o
);
    import abp_pkg::*;

    localparam int unsigned CW  = $clog2(OVS);
    localparam int unsigned IW  = $clog2(DW);
    localparam int unsigned MID = OVS / 2;

    typedef struct packed {
        logic [1:0]    sync;
        rx_state_e     st;
        logic          armed;
        logic [CW-1:0] cnt;
        logic [IW-1:0] idx;
        logic          s_lo;
        logic          s_mid;
        logic          s_hi;
        logic [DW-1:0] sh;
    } rx_s;

    rx_s  q, d;
    logic line;
    logic vote_bit;

    assign line     = q.sync[1];
    assign vote_bit = maj3(q.s_lo, q.s_mid, q.s_hi);

    always_comb begin
        d      = q;
        req_o  = 1'b0;
        d.sync = {q.sync[0], rxd_i};
        if (!en_i) begin
            d.st    = RX_IDLE;
            d.armed = 1'b0;
            d.cnt   = '0;
        end else if (tick_i) begin
            if (q.st == RX_IDLE) begin
                if (line) begin
                    d.armed = 1'b1;
                end else if (q.armed) begin
                    d.st    = RX_START;
                    d.cnt   = '0;
                    d.armed = 1'b0;
                end
            end else begin
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == CW'(MID - 1)) d.s_lo  = line;
                if (q.cnt == CW'(MID))     d.s_mid = line;
                if (q.cnt == CW'(MID + 1)) d.s_hi  = line;
                case (q.st)
                    RX_START: begin
                        if (q.cnt == CW'(OVS - 1)) begin
                            d.cnt = '0;
                            if (vote_bit) begin
                                d.st = RX_IDLE;
                            end else begin
                                d.st  = RX_DATA;
                                d.idx = '0;
                            end
                        end
                    end
                    RX_DATA: begin
                        if (q.cnt == CW'(OVS - 1)) begin
                            d.cnt = '0;
                            d.sh  = {vote_bit, q.sh[DW-1:1]};
                            d.idx = q.idx + 1'b1;
                            if (q.idx == IW'(DW - 1)) begin
                                d.st = RX_STOP;
                            end
                        end
                    end
                    RX_STOP: begin
                        if (q.cnt == CW'(MID + 1)) begin
                            req_o = 1'b1;
                            d.st  = RX_IDLE;
                        end
                    end
                    default: d.st = RX_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sync  <= 2'b11;
            q.st    <= RX_IDLE;
            q.armed <= 1'b0;
            q.cnt   <= '0;
            q.idx   <= '0;
            q.s_lo  <= 1'b1;
            q.s_mid <= 1'b1;
            q.s_hi  <= 1'b1;
            q.sh    <= '0;
        end else begin
            q <= d;
        end
    end

    assign data_o = q.sh;
    assign stop_o = maj3(q.s_lo, q.s_mid, line);

    // R4
    rx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (q.st == RX_IDLE));

    // R5
    commit_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |=> (q.st == RX_IDLE && !q.armed));

endmodule

// File: rtl/abp_flags.sv
module abp_flags #(
    parameter int unsigned DW = abp_pkg::ABP_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_set_i,
    input  logic          tx_clr_i,
    input  logic          rx_req_i,
    input  logic [DW-1:0] rx_data_i,
    input  logic          rx_stop_i,
    input  logic          rx_clr_i,
    input  logic          mp_qual_i,
    input  logic          irq_en_i,
    output logic          tx_done_o,
    output logic          rx_done_o,
    output logic          bit9_o,
    output logic [DW-1:0] buf_o,
    output logic          irq_o
);
    typedef struct packed {
        logic          tx_f;
        logic          rx_f;
        logic          b9;
        logic [DW-1:0] rbuf;
    } fl_s;

    fl_s  q, d;
    logic commit;

    assign commit = rx_req_i && !q.rx_f && (!mp_qual_i || rx_stop_i);

    always_comb begin
        d      = q;
        d.tx_f = tx_clr_i ? 1'b0 : (tx_set_i ? 1'b1 : q.tx_f);
        d.rx_f = rx_clr_i ? 1'b0 : (commit   ? 1'b1 : q.rx_f);
        if (commit) begin
            d.rbuf = rx_data_i;
            d.b9   = rx_stop_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign tx_done_o = q.tx_f;
    assign rx_done_o = q.rx_f;
    assign bit9_o    = q.b9;
    assign buf_o     = q.rbuf;
    assign irq_o     = irq_en_i && (q.tx_f || q.rx_f);

    // R10
    tx_clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_clr_i |=> !tx_done_o);

    // R10
    rx_clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_clr_i |=> !rx_done_o);

    // R2
    tx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_set_i && !tx_clr_i) |=> tx_done_o);

    // R6
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_req_i && rx_done_o) |=> ($stable(buf_o) && $stable(bit9_o)));

    // R7
    mp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_req_i && mp_qual_i && !rx_stop_i) |=> ($stable(buf_o) && $stable(bit9_o)));

    // R9
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> irq_en_i);

endmodule

// File: rtl/async_byte_port.sv
module async_byte_port #(
    parameter int unsigned OVS    = 16,
    parameter int unsigned DATA_W = abp_pkg::ABP_DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              tx_wr_i,
    input  logic [DATA_W-1:0] tx_data_i,
    output logic              txd_o,
    input  logic              rxd_i,
    input  logic              rx_en_i,
    input  logic              mp_qual_i,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_bit9_o,
    output logic              tx_done_o,
    output logic              rx_done_o,
    input  logic              tx_done_clr_i,
    input  logic              rx_done_clr_i,
    input  logic              irq_en_i,
    output logic              irq_o
);
    logic              tx_set;
    logic              rx_req;
    logic [DATA_W-1:0] rx_word;
    logic              rx_stop;

    abp_tx #(.OVS(OVS), .DW(DATA_W)) u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick_i),
        .wr_i   (tx_wr_i),
        .data_i (tx_data_i),
        .txd_o  (txd_o),
        .set_o  (tx_set)
    );

    abp_rx #(.OVS(OVS), .DW(DATA_W)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick_i),
        .rxd_i  (rxd_i),
        .en_i   (rx_en_i),
        .req_o  (rx_req),
        .data_o (rx_word),
        .stop_o (rx_stop)
    );

    abp_flags #(.DW(DATA_W)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_set_i  (tx_set),
        .tx_clr_i  (tx_done_clr_i),
        .rx_req_i  (rx_req),
        .rx_data_i (rx_word),
        .rx_stop_i (rx_stop),
        .rx_clr_i  (rx_done_clr_i),
        .mp_qual_i (mp_qual_i),
        .irq_en_i  (irq_en_i),
        .tx_done_o (tx_done_o),
        .rx_done_o (rx_done_o),
        .bit9_o    (rx_bit9_o),
        .buf_o     (rx_data_o),
        .irq_o     (irq_o)
    );

endmodule

// File: tb/async_byte_port_bench.sv
`timescale 1ns/1ps
module async_byte_port_bench;
    localparam int OVS  = 16;
    localparam int TDIV = 2;
    localparam int BT   = OVS * TDIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       tx_wr = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       txd;
    logic       rxd = 1'b1;
    logic       rx_en = 1'b0;
    logic       mp = 1'b0;
    logic [7:0] rx_data;
    logic       bit9, tx_done, rx_done, irq;
    logic       tx_clr = 1'b0;
    logic       rx_clr = 1'b0;
    logic       irq_en = 1'b0;

    int n_chk = 0;
    int n_err = 0;
    bit done_flag = 1'b0;

    always #4 clk = ~clk;

    initial begin
        forever begin
            @(negedge clk);
            tick = ~tick;
        end
    end

    async_byte_port #(.OVS(OVS)) u_async_byte_port (
        .clk(clk), .rst_n(rst_n), .tick_i(tick),
        .tx_wr_i(tx_wr), .tx_data_i(tx_data), .txd_o(txd),
        .rxd_i(rxd), .rx_en_i(rx_en), .mp_qual_i(mp),
        .rx_data_o(rx_data), .rx_bit9_o(bit9),
        .tx_done_o(tx_done), .rx_done_o(rx_done),
        .tx_done_clr_i(tx_clr), .rx_done_clr_i(rx_clr),
        .irq_en_i(irq_en), .irq_o(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic frame_bit(input logic [7:0] b, input int i, input logic stop);
        if (i == 0) return 1'b0;
        if (i == 9) return stop;
        return b[i-1];
    endfunction

    function automatic logic exp_irq(input logic en, input logic t, input logic r);
        return en & (t | r);
    endfunction

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_tx_clr();
        tx_clr = 1'b1; wait_cyc(1); tx_clr = 1'b0;
    endtask

    task automatic pulse_rx_clr();
        rx_clr = 1'b1; wait_cyc(1); rx_clr = 1'b0;
    endtask

    // Sends one byte and checks every bit at mid-bit.
    task automatic tx_frame(input logic [7:0] b, input bit inject, input bit hold_clr);
        int guard;
        tx_clr  = hold_clr;
        tx_data = b;
        tx_wr   = 1'b1;
        wait_cyc(1);
        tx_wr   = 1'b0;
        guard   = 0;
        while (txd && guard < 3 * BT) begin
            wait_cyc(1);
            guard++;
        end
        wait_cyc(BT / 2);
        chk("R1 start bit", {31'd0, txd}, 32'd0);
        for (int i = 1; i <= 8; i++) begin
            if (inject && i == 2) begin
                tx_data = ~b; tx_wr = 1'b1; wait_cyc(1); tx_wr = 1'b0;
                wait_cyc(BT - 1);
            end else begin
                wait_cyc(BT);
            end
            chk(inject ? "R3 data bit" : "R1 data bit", {31'd0, txd}, {31'd0, frame_bit(b, i, 1'b1)});
        end
        chk("R2 flag low in data", {31'd0, tx_done}, 32'd0);
        wait_cyc(BT);
        chk("R1 stop bit", {31'd0, txd}, 32'd1);
        chk(hold_clr ? "R10 clear beats set" : "R2 flag at stop", {31'd0, tx_done}, {31'd0, !hold_clr});
        wait_cyc(BT);
        tx_clr = 1'b0;
        chk("R1 idle high", {31'd0, txd}, 32'd1);
    endtask

    // Drives one frame on rxd; drop_at >= 0 lowers rx_en at that bit.
    task automatic rx_frame(input logic [7:0] b, input logic stop, input int drop_at);
        for (int i = 0; i <= 9; i++) begin
            rxd = frame_bit(b, i, stop);
            if (i == drop_at) rx_en = 1'b0;
            wait_cyc(BT);
        end
        rxd = 1'b1;
        wait_cyc(BT / 2);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] b;
        logic [7:0] held;
        int seen_low;
        int seed;
        seed = $urandom(32'd2024);
        wait_cyc(5);
        chk("R11 txd", {31'd0, txd}, 32'd1);
        chk("R11 tx flag", {31'd0, tx_done}, 32'd0);
        chk("R11 rx flag", {31'd0, rx_done}, 32'd0);
        chk("R11 bit9", {31'd0, bit9}, 32'd0);
        chk("R11 irq", {31'd0, irq}, 32'd0);
        chk("R11 data", {24'd0, rx_data}, 32'd0);
        rst_n = 1'b1;
        irq_en = 1'b1;
        wait_cyc(4);

        // Transmit: random bytes plus fixed corners
        for (int k = 0; k < 6; k++) begin
            b = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : 8'($urandom);
            tx_frame(b, 1'b0, 1'b0);
            chk("R9 irq from tx", {31'd0, irq}, {31'd0, exp_irq(irq_en, tx_done, rx_done)});
            pulse_tx_clr();
            chk("R10 tx clear", {31'd0, tx_done}, 32'd0);
        end

        // R3: write during frame
        tx_frame(8'hA5, 1'b1, 1'b0);
        seen_low = 0;
        for (int c = 0; c < 2 * BT; c++) begin
            if (!txd) seen_low++;
            wait_cyc(1);
        end
        chk("R3 no second frame", seen_low, 0);
        pulse_tx_clr();

        // R10: clear held across stop start
        tx_frame(8'h3C, 1'b0, 1'b1);

        // Receive: random bytes
        rx_en = 1'b1;
        wait_cyc(BT);
        for (int k = 0; k < 6; k++) begin
            b = (k == 0) ? 8'h01 : (k == 1) ? 8'h80 : 8'($urandom);
            rx_frame(b, 1'b1, -1);
            chk("R5 rx flag", {31'd0, rx_done}, 32'd1);
            chk("R5 rx data", {24'd0, rx_data}, {24'd0, b});
            chk("R5 bit9", {31'd0, bit9}, 32'd1);
            chk("R9 irq from rx", {31'd0, irq}, 32'd1);
            pulse_rx_clr();
            chk("R10 rx clear", {31'd0, rx_done}, 32'd0);
        end

        // R6: flag still set
        held = 8'h5A;
        rx_frame(held, 1'b1, -1);
        rx_frame(8'hC3, 1'b0, -1);
        chk("R6 data kept", {24'd0, rx_data}, {24'd0, held});
        chk("R6 bit9 kept", {31'd0, bit9}, 32'd1);
        chk("R6 flag kept", {31'd0, rx_done}, 32'd1);
        irq_en = 1'b0;
        wait_cyc(1);
        chk("R9 irq gated", {31'd0, irq}, 32'd0);
        irq_en = 1'b1;
        pulse_rx_clr();

        // R7: qualification
        mp = 1'b1;
        rx_frame(8'h77, 1'b0, -1);
        wait_cyc(BT);
        chk("R7 qualified drop flag", {31'd0, rx_done}, 32'd0);
        chk("R7 qualified drop data", {24'd0, rx_data}, {24'd0, held});
        rx_frame(8'h69, 1'b1, -1);
        chk("R7 qualified accept", {24'd0, rx_data}, 32'h69);
        pulse_rx_clr();
        mp = 1'b0;
        rx_frame(8'h96, 1'b0, -1);
        wait_cyc(BT);
        chk("R7 unqualified data", {24'd0, rx_data}, 32'h96);
        chk("R7 unqualified bit9", {31'd0, bit9}, 32'd0);
        pulse_rx_clr();

        // R4: disabled and dropped mid-frame
        rx_en = 1'b0;
        rx_frame(8'h12, 1'b1, -1);
        chk("R4 disabled flag", {31'd0, rx_done}, 32'd0);
        chk("R4 disabled data", {24'd0, rx_data}, 32'h96);
        rx_en = 1'b1;
        wait_cyc(BT);
        rx_frame(8'h34, 1'b1, 4);
        chk("R4 dropped flag", {31'd0, rx_done}, 32'd0);
        chk("R4 dropped data", {24'd0, rx_data}, 32'h96);
        rx_en = 1'b1;
        wait_cyc(BT);

        // R8: false start
        rxd = 1'b0;
        wait_cyc(3 * TDIV);
        rxd = 1'b1;
        wait_cyc(2 * BT);
        chk("R8 false start flag", {31'd0, rx_done}, 32'd0);
        b = 8'($urandom);
        rx_frame(b, 1'b1, -1);
        chk("R8 frame after glitch", {24'd0, rx_data}, {24'd0, b});
        chk("R8 flag after glitch", {31'd0, rx_done}, 32'd1);

        finish_run();
    end

endmodule